// File: doc/BRIEF.md
# Multi-Exposure Linear HDR Merger

The block builds one wide linear pixel value from four 12-bit readings of the same pixel, each taken with a different accumulation time. The accumulation times shrink by fixed factors from the longest to the shortest reading: 10 between the first and second, then 12, then 12 again. The shortest reading therefore spans 1440 times the light range of the longest.

For each pixel the block takes the longest reading that has not clipped and multiplies it by that reading's gain (1, 10, 120 or 1440), which puts every pixel on one common linear scale. The readings arrive as a tagged stream. The block checks that the tags arrive in order and flags any break in the sequence.

The gains are fixed multiplications built from shifts and adds, not general multipliers. The clipping threshold is a live input, so software can tune it for the sensor in use.

Top module: `hdr_merge`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `out_valid` and `out_err` are 0.
- R2: The exposure tag is encoded as 0 = longest, 1 = second, 2 = third, 3 = shortest. A reading with tag t is scaled by 1, 10, 120 or 1440 for t = 0, 1, 2, 3 respectively.
- R3: The merged value is the scaled reading of the lowest-tagged (longest) reading of the pixel that is not saturated.
- R4: A reading is saturated when its code is greater than or equal to `sat_thresh`, sampled in the cycle the reading arrives. A code of `sat_thresh`−1 is not saturated.
- R5: When all four readings of a pixel are saturated, the merged value is the shortest reading times 1440.
- R6: `out_valid` is high for exactly one cycle: the cycle after an in-order tag-3 reading is accepted. It is never high in two consecutive cycles.
- R7: A reading whose tag differs from the expected next tag raises `out_err` for one cycle in the following cycle. The pixel being collected is dropped and produces no `out_valid`.
- R8: After an error, the expected tag is 1 if the offending reading had tag 0, which then opens a new pixel. Otherwise the expected tag is 0.
- R9: Cycles with `in_valid` low have no effect. Readings of one pixel may be separated by any number of idle cycles.
- R10: `out_value` is 23 bits wide and never exceeds 4095 × 1440 = 5896800 while `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sat_thresh | input | 12 | Saturation threshold (code >= threshold means clipped) |
| in_valid | input | 1 | A reading is present this cycle |
| in_tag | input | 2 | Exposure tag of the reading, 0 = longest .. 3 = shortest |
| in_code | input | 12 | ADC code of the reading |
| out_valid | output | 1 | Merged value valid pulse |
| out_value | output | 23 | Merged linear value |
| out_err | output | 1 | Tag sequence error pulse |

## Verification
Both results have a latency of one register stage. The merged value and `out_valid` appear in the cycle after the tag-3 reading is taken. `out_err` appears in the cycle after the reading whose tag broke the sequence.

The bench drives inputs on the falling edge. A behavioural model updates on the rising edge from those inputs, and the design's outputs are compared with the model on the next falling edge, every cycle. Hand-computed values for the boundary pixels are checked in that same falling-edge slot, one cycle after the shortest reading is driven.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
  localparam int CODE_W  = 12;
  localparam int OUT_W   = 23;
  localparam int N_EXP   = 4;
  localparam int TAG_W   = $clog2(N_EXP);
  localparam int MAX_OUT = ((1 << CODE_W) - 1) * 1440;

  typedef enum logic [TAG_W-1:0] {
    EXP_LONG   = 2'd0,
    EXP_SHORT  = 2'd1,
    EXP_VSHORT = 2'd2,
    EXP_XSHORT = 2'd3
  } exp_tag_t;

  typedef logic [OUT_W-1:0] wide_t;

  // gain 10 = 8 + 2
  function automatic wide_t times10(input wide_t x);
    return (x << 3) + (x << 1);
  endfunction

  // gain 120 = 128 - 8
  function automatic wide_t times120(input wide_t x);
    return (x << 7) - (x << 3);
  endfunction

  // gain 1440 = 1024 + 256 + 128 + 32
  function automatic wide_t times1440(input wide_t x);
    return (x << 10) + (x << 8) + (x << 7) + (x << 5);
  endfunction
endpackage

// File: rtl/hdr_scaler.sv
module hdr_scaler
  import hdr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CODE_W-1:0]       code,
  output logic [N_EXP-1:0][OUT_W-1:0] prod
);
  wide_t ext;
  assign ext = wide_t'(code);

  for (genvar g = 0; g < N_EXP; g++) begin : g_gain
    if (g == 0) begin : g_unit
      assign prod[g] = ext;
    end else if (g == 1) begin : g_x10
      assign prod[g] = times10(ext);
    end else if (g == 2) begin : g_x120
      assign prod[g] = times120(ext);
    end else begin : g_x1440
      assign prod[g] = times1440(ext);
    end
  end

  // R2: shorter exposures always carry a strictly larger gain
  gain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code != '0) |-> (prod[3] > prod[2]) && (prod[2] > prod[1]) && (prod[1] > prod[0]));
endmodule

// File: rtl/hdr_seq.sv
module hdr_seq
  import hdr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  output logic             take,
  output logic             bad,
  output logic             finish
);
  logic [TAG_W-1:0] exp_next;

  assign bad    = in_valid && (in_tag != exp_next);
  assign take   = in_valid && ((in_tag == exp_next) || (in_tag == EXP_LONG));
  assign finish = take && !bad && (in_tag == EXP_XSHORT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_next <= EXP_LONG;
    end else if (in_valid) begin
      if (bad) begin
        exp_next <= (in_tag == EXP_LONG) ? EXP_SHORT : EXP_LONG;
      end else begin
        exp_next <= in_tag + 1'b1;
      end
    end
  end

  // R7: an out-of-order reading never completes a pixel
  bad_no_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> !finish);

  // R8: after an error the next expected tag is 0 or 1
  restart_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> (exp_next == EXP_LONG) || (exp_next == EXP_SHORT));
endmodule

// File: rtl/hdr_select.sv
module hdr_select
  import hdr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        take,
  input  logic                        bad,
  input  logic                        finish,
  input  logic [TAG_W-1:0]            tag,
  input  logic [CODE_W-1:0]           code,
  input  logic [CODE_W-1:0]           thresh,
  input  logic [N_EXP-1:0][OUT_W-1:0] prod,
  output logic                        out_valid,
  output logic [OUT_W-1:0]            out_value,
  output logic                        out_err
);
  logic       sat;
  logic       found;
  wide_t      hold;
  wide_t      pick;

  assign sat  = (code >= thresh);
  assign pick = prod[tag];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      found     <= 1'b0;
      hold      <= '0;
      out_valid <= 1'b0;
      out_value <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= finish;
      out_err   <= bad;
      if (take) begin
        if (tag == EXP_LONG) begin
          found <= !sat;
          hold  <= pick;
        end else if (!found && !sat) begin
          found <= 1'b1;
          hold  <= pick;
        end
      end
      if (finish) begin
        out_value <= found ? hold : pick;
      end
    end
  end

  // R6: result one cycle after the accepted shortest reading
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(finish));

  // R6: single-cycle pulse
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7: error and result never in the same cycle
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> !out_valid);

  // R10: merged value within the scaled code range
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_value <= OUT_W'(MAX_OUT)));
endmodule

// File: rtl/hdr_merge.sv
module hdr_merge
  import hdr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] sat_thresh,
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_value,
  output logic              out_err
);
  logic                        take;
  logic                        bad;
  logic                        finish;
  logic [N_EXP-1:0][OUT_W-1:0] prod;

  hdr_seq i_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .take(take), .bad(bad), .finish(finish)
  );

  hdr_scaler i_scaler (
    .clk(clk), .rst_n(rst_n), .code(in_code), .prod(prod)
  );

  hdr_select i_select (
    .clk(clk), .rst_n(rst_n), .take(take), .bad(bad), .finish(finish),
    .tag(in_tag), .code(in_code), .thresh(sat_thresh), .prod(prod),
    .out_valid(out_valid), .out_value(out_value), .out_err(out_err)
  );

  // R9: idle input cycles produce no output event
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_err);
endmodule

// File: tb/test_hdr_merge.sv
module test_hdr_merge;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] sat_thresh = 12'd4000;
  logic        in_valid = 1'b0;
  logic [1:0]  in_tag = '0;
  logic [11:0] in_code = '0;
  logic        out_valid;
  logic [22:0] out_value;
  logic        out_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hdr_merge i_hdr_merge (
    .clk(clk), .rst_n(rst_n), .sat_thresh(sat_thresh), .in_valid(in_valid),
    .in_tag(in_tag), .in_code(in_code), .out_valid(out_valid),
    .out_value(out_value), .out_err(out_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  int  gains[4] = '{1, 10, 120, 1440};
  int  m_next = 0;
  int  m_code[$];
  bit  m_sat[$];
  bit  exp_valid = 0;
  bit  exp_err = 0;
  int  exp_value = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_next = 0; m_code.delete(); m_sat.delete();
      exp_valid = 0; exp_err = 0;
    end else begin
      exp_valid = 0; exp_err = 0;
      if (in_valid) begin
        if (int'(in_tag) != m_next) begin
          exp_err = 1;
          m_code.delete(); m_sat.delete();
          if (in_tag == 0) begin
            m_code.push_back(int'(in_code)); m_sat.push_back(in_code >= sat_thresh);
            m_next = 1;
          end else m_next = 0;
        end else begin
          m_code.push_back(int'(in_code)); m_sat.push_back(in_code >= sat_thresh);
          if (in_tag == 3) begin
            exp_value = m_code[3] * gains[3];
            for (int i = 3; i >= 0; i--) if (!m_sat[i]) exp_value = m_code[i] * gains[i];
            exp_valid = 1;
            m_code.delete(); m_sat.delete();
            m_next = 0;
          end else m_next = m_next + 1;
        end
      end
    end
  end

  task automatic check(string req, int got, int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, expv, $time);
    end
  endtask

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 out_valid timing", int'(out_valid), int'(exp_valid));
      check("R7 out_err timing", int'(out_err), int'(exp_err));
      if (exp_valid) check("R3 merged value vs model", int'(out_value), exp_value);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic put(int tag, int code);
    @(negedge clk);
    in_valid = 1'b1; in_tag = 2'(tag); in_code = 12'(code);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic pixel(int a, int b, int c, int d);
    put(0, a); put(1, b); put(2, c); put(3, d);
    idle(1);
  endtask

  task automatic pixel_expect(string req, int a, int b, int c, int d, int expv);
    pixel(a, b, c, d);
    check({req, " valid"}, int'(out_valid), 1);
    check(req, int'(out_value), expv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", int'(out_valid), 0);
    check("R1 reset out_err", int'(out_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release out_valid", int'(out_valid), 0);
    check("R1 after release out_err", int'(out_err), 0);

    pixel_expect("R3 longest unsaturated", 100, 1000, 3000, 4000, 100);
    pixel_expect("R4 equal threshold saturates, R2 gain 10", 4000, 300, 5, 1, 3000);
    pixel_expect("R2 gain 120", 4095, 4001, 3999, 10, 479880);
    pixel_expect("R2 gain 1440", 4095, 4095, 4095, 7, 10080);
    pixel_expect("R5 R10 all saturated max", 4095, 4095, 4095, 4095, 5896800);
    pixel_expect("R4 one below threshold", 3999, 10, 10, 10, 3999);
    sat_thresh = 12'd100;
    pixel_expect("R4 lowered threshold", 100, 99, 1, 1, 990);
    pixel_expect("R5 all above lowered threshold", 200, 300, 400, 500, 720000);
    sat_thresh = 12'd4000;

    // R7: missing tag 2
    put(0, 10); put(1, 10); put(3, 10); idle(1);
    check("R7 error on skipped tag", int'(out_err), 1);
    check("R7 no result for dropped pixel", int'(out_valid), 0);
    // R8: stray tag after error also errors, then tag 0 restarts
    put(2, 10); idle(1);
    check("R8 stray tag errors", int'(out_err), 1);
    // R8: tag 0 mid-pixel opens new pixel
    put(0, 4095); put(1, 50); put(0, 20); idle(1);
    check("R8 restart flagged", int'(out_err), 1);
    put(1, 4095); put(2, 4095); put(3, 4095); idle(1);
    check("R8 restarted pixel result", int'(out_value), 20);

    // R9: gaps between readings
    put(0, 4095); idle(3); put(1, 4095); idle(2); put(2, 33); idle(5); put(3, 1); idle(1);
    check("R9 result across idle gaps", int'(out_value), 3960);
    check("R9 valid across idle gaps", int'(out_valid), 1);

    // random traffic against the model
    for (int p = 0; p < 400; p++) begin
      sat_thresh = ($urandom_range(0, 3) == 0) ? 12'($urandom_range(1, 4095)) : 12'd4000;
      for (int t = 0; t < 4; t++) begin
        int tg = ($urandom_range(0, 19) == 0) ? int'($urandom_range(0, 3)) : t;
        int cd = ($urandom_range(0, 1) == 0) ? int'($urandom_range(3900, 4095))
                                             : int'($urandom_range(0, 4095));
        put(tg, cd);
        if ($urandom_range(0, 4) == 0) idle($urandom_range(1, 3));
      end
    end
    idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion (R6)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule